// File: doc/BRIEF.md
# Triggered Signal Capture Analyzer

This block is an on-chip logic analyzer. Once armed, it writes the concatenated probe ports into a circular on-chip memory on every clock cycle. It also compares each probe port against its own compare value under a per-port mask. The per-port matches are merged into a single trigger, either by requiring all enabled ports to match or by accepting any one of them.

When the trigger fires, the block keeps sampling only as long as needed for the trigger sample to land at a programmed slot of the window. It then stops writing and holds the memory. The stored window is read back in time order: read address 0 is the oldest sample. Each read returns a flag that marks slots not written since the last arming.

Typical use is to program the compare, mask, enable, combine and position inputs, pulse arm, wait for the done flag, and then sweep the read address across the window.

Top module: `trig_capture_analyzer`

## Requirements
- R1: After synchronous reset, armed_o, triggered_o and done_o are all low.
- R2: A one-cycle arm_i pulse makes armed_o high and triggered_o and done_o low from the next cycle. This clears any previous trigger, done state and sample count, but leaves memory contents untouched.
- R3: While armed_o is high, the block stores the live probe_i value once per clock cycle, including cycles before the trigger. armed_o stays high until capture completes.
- R4: Port p (probe_i bits p*PW+PW-1 down to p*PW) matches when (probe & mask) equals (value & mask) for that port's slices. The match is judged on the probe value of the same cycle, and the sample stored in that cycle is the trigger sample. triggered_o rises one cycle later.
- R5: combine_all_i = 1 requires every enabled port to match; combine_all_i = 0 requires at least one enabled port to match. A port whose port_en_i bit is 0 never affects the trigger, and with no port enabled the block never triggers.
- R6: After the trigger sample, exactly DEPTH-1-trig_pos_i further samples are stored. done_o rises in the cycle after the last stored sample, so with trig_pos_i = DEPTH-1 it rises in the cycle after the trigger itself. The trigger sample is then read at address trig_pos_i.
- R7: While done_o is high and arm_i is low, no sample is written, and done_o stays high until the next arm.
- R8: rd_data_o returns, one cycle after rd_addr_i is presented, the window sample at that logical index. Index 0 is the oldest sample and index DEPTH-1 is the newest.
- R9: If fewer than DEPTH samples were stored since arming, the rd_valid_o flag returned with a read is 1 only for the newest stored indices. It is 0 for the earlier indices, which covers an early trigger that arrives before trig_pos_i pre-trigger samples exist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_i | input | NPORTS*PW | Live probe ports, port p in slice p |
| cmp_value_i | input | NPORTS*PW | Per-port compare values |
| cmp_mask_i | input | NPORTS*PW | Per-port compare masks (1 = bit compared) |
| port_en_i | input | NPORTS | Per-port trigger enable |
| combine_all_i | input | 1 | 1: all enabled ports must match; 0: any enabled port |
| trig_pos_i | input | log2(DEPTH) | Window slot of the trigger sample |
| arm_i | input | 1 | Start a new capture (pulse) |
| armed_o | output | 1 | Capture in progress |
| triggered_o | output | 1 | Trigger seen in this capture |
| done_o | output | 1 | Capture complete, memory frozen |
| rd_addr_i | input | log2(DEPTH) | Logical read index, 0 = oldest |
| rd_data_o | output | NPORTS*PW | Stored sample, one cycle after address |
| rd_valid_o | output | 1 | Slot was written in this capture |

## Verification
Two pairs of events can land on the same clock edge. A trigger with trig_pos_i at the last slot coincides with the end of capture. A trigger on the very first sample after arming coincides with the start of the window. The bench provokes the first by programming an all-ports match that can only occur once, with the position at DEPTH-1. It provokes the second with an all-zero mask and position 0. In both cases it judges the exact cycle in which triggered_o and done_o rise against its own sample model, and then checks the full readout for the trigger sample at the programmed slot and for the valid flags.

// File: rtl/tca_pkg.sv
`timescale 1ns/1ps
package tca_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_PRE  = 2'd1,
        CAP_POST = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_e;

    typedef enum logic {
        COMB_ANY = 1'b0,
        COMB_ALL = 1'b1
    } comb_mode_e;

    function automatic int ptr_bits(input int depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/tca_match.sv
`timescale 1ns/1ps
module tca_match import tca_pkg::*; #(
    parameter int NPORTS = 2,
    parameter int PW     = 8
) (
    input  logic [NPORTS*PW-1:0] probe_i,
    input  logic [NPORTS*PW-1:0] value_i,
    input  logic [NPORTS*PW-1:0] mask_i,
    input  logic [NPORTS-1:0]    en_i,
    input  comb_mode_e           mode_i,
    output logic                 hit_o
);

    logic [NPORTS-1:0] port_hit;

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            assign port_hit[p] =
                ((probe_i[p*PW +: PW] ^ value_i[p*PW +: PW]) & mask_i[p*PW +: PW]) == '0;
        end
    endgenerate

    always_comb begin
        if (en_i == '0) begin
            hit_o = 1'b0;
        end else if (mode_i == COMB_ALL) begin
            hit_o = &(port_hit | ~en_i);
        end else begin
            hit_o = |(port_hit & en_i);
        end
    end

endmodule

// File: rtl/tca_ctrl.sv
`timescale 1ns/1ps
module tca_ctrl import tca_pkg::*; #(
    parameter  int DEPTH = 64,
    localparam int AW    = ptr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_i,
    input  logic          hit_i,
    input  logic [AW-1:0] pos_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_ptr_o,
    output logic [AW:0]   fill_o,
    output logic          armed_o,
    output logic          triggered_o,
    output logic          done_o
);

    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] ONE_P = AW'(1);
    localparam logic [AW:0]   FULL  = (AW+1)'(DEPTH);
    localparam logic [AW:0]   ONE_F = (AW+1)'(1);

    cap_state_e    state_q;
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] post_left_q;
    logic [AW:0]   fill_q;
    logic          trig_q;
    logic          capturing;

    assign capturing = (state_q == CAP_PRE) || (state_q == CAP_POST);
    assign wr_en_o   = capturing && !arm_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= CAP_IDLE;
            wr_ptr_q    <= '0;
            post_left_q <= '0;
            fill_q      <= '0;
            trig_q      <= 1'b0;
        end else if (arm_i) begin
            state_q     <= CAP_PRE;
            post_left_q <= '0;
            fill_q      <= '0;
            trig_q      <= 1'b0;
        end else if (wr_en_o) begin
            wr_ptr_q <= wr_ptr_q + ONE_P;
            if (fill_q != FULL) begin
                fill_q <= fill_q + ONE_F;
            end
            if (state_q == CAP_PRE) begin
                if (hit_i) begin
                    trig_q <= 1'b1;
                    if (pos_i == LAST) begin
                        state_q <= CAP_DONE;
                    end else begin
                        post_left_q <= LAST - pos_i;
                        state_q     <= CAP_POST;
                    end
                end
            end else begin
                if (post_left_q == ONE_P) begin
                    state_q <= CAP_DONE;
                end else begin
                    post_left_q <= post_left_q - ONE_P;
                end
            end
        end
    end

    assign wr_ptr_o    = wr_ptr_q;
    assign fill_o      = fill_q;
    assign armed_o     = capturing;
    assign triggered_o = trig_q;
    assign done_o      = (state_q == CAP_DONE);

endmodule

// File: rtl/tca_ram.sv
`timescale 1ns/1ps
module tca_ram import tca_pkg::*; #(
    parameter  int DEPTH = 64,
    parameter  int DW    = 16,
    localparam int AW    = ptr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_o <= mem_q[raddr_i];
    end

endmodule

// File: rtl/trig_capture_analyzer.sv
`timescale 1ns/1ps
module trig_capture_analyzer import tca_pkg::*; #(
    parameter  int NPORTS = 2,
    parameter  int PW     = 8,
    parameter  int DEPTH  = 64,
    localparam int DW     = NPORTS * PW,
    localparam int AW     = ptr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     probe_i,
    input  logic [DW-1:0]     cmp_value_i,
    input  logic [DW-1:0]     cmp_mask_i,
    input  logic [NPORTS-1:0] port_en_i,
    input  logic              combine_all_i,
    input  logic [AW-1:0]     trig_pos_i,
    input  logic              arm_i,
    output logic              armed_o,
    output logic              triggered_o,
    output logic              done_o,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DW-1:0]     rd_data_o,
    output logic              rd_valid_o
);

    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    logic          hit;
    logic          cap_we;
    logic [AW-1:0] wr_ptr;
    logic [AW:0]   fill;
    logic [AW-1:0] rd_phys;

    tca_match #(.NPORTS(NPORTS), .PW(PW)) u_match (
        .probe_i (probe_i),
        .value_i (cmp_value_i),
        .mask_i  (cmp_mask_i),
        .en_i    (port_en_i),
        .mode_i  (comb_mode_e'(combine_all_i)),
        .hit_o   (hit)
    );

    tca_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .hit_i       (hit),
        .pos_i       (trig_pos_i),
        .wr_en_o     (cap_we),
        .wr_ptr_o    (wr_ptr),
        .fill_o      (fill),
        .armed_o     (armed_o),
        .triggered_o (triggered_o),
        .done_o      (done_o)
    );

    // Oldest slot is the next one the write pointer would have used.
    assign rd_phys = wr_ptr + rd_addr_i;

    tca_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk     (clk),
        .we_i    (cap_we),
        .waddr_i (wr_ptr),
        .wdata_i (probe_i),
        .raddr_i (rd_phys),
        .rdata_o (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= ({1'b0, rd_addr_i} >= (FULL - fill));
        end
    end

endmodule

// File: rtl/tca_chk.sv
`timescale 1ns/1ps
module tca_chk #(
    parameter int NPORTS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              arm_i,
    input logic [NPORTS-1:0] port_en_i,
    input logic              cap_we,
    input logic              armed_o,
    input logic              triggered_o,
    input logic              done_o
);

    // R2
    arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (armed_o && !triggered_o && !done_o));

    // R3
    trig_needs_armed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(triggered_o) |-> $past(armed_o));

    // R5
    no_enable_no_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (port_en_i == '0 && !arm_i && !triggered_o) |=> !triggered_o);

    // R6
    done_after_trig_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> triggered_o);

    // R7
    frozen_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !arm_i) |-> !cap_we);

    // R7
    done_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !arm_i) |=> done_o);

    // R3
    state_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({armed_o, done_o}));

endmodule

bind trig_capture_analyzer tca_chk #(.NPORTS(NPORTS)) u_tca_chk (
    .clk         (clk),
    .rst         (rst),
    .arm_i       (arm_i),
    .port_en_i   (port_en_i),
    .cap_we      (cap_we),
    .armed_o     (armed_o),
    .triggered_o (triggered_o),
    .done_o      (done_o)
);

// File: tb/test_trig_capture_analyzer.sv
`timescale 1ns/1ps
module test_trig_capture_analyzer;

    localparam int NP    = 2;
    localparam int PW    = 8;
    localparam int DEPTH = 64;
    localparam int DW    = NP * PW;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] probe = '0;
    logic [DW-1:0] cmp_value = '0;
    logic [DW-1:0] cmp_mask = '0;
    logic [NP-1:0] port_en = '0;
    logic          comb_all = 1'b0;
    logic [AW-1:0] trig_pos = '0;
    logic          arm = 1'b0;
    logic          armed, triggered, done;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    always #2.5 clk = ~clk;

    trig_capture_analyzer #(.NPORTS(NP), .PW(PW), .DEPTH(DEPTH)) i_trig_capture_analyzer (
        .clk           (clk),
        .rst           (rst),
        .probe_i       (probe),
        .cmp_value_i   (cmp_value),
        .cmp_mask_i    (cmp_mask),
        .port_en_i     (port_en),
        .combine_all_i (comb_all),
        .trig_pos_i    (trig_pos),
        .arm_i         (arm),
        .armed_o       (armed),
        .triggered_o   (triggered),
        .done_o        (done),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .rd_valid_o    (rd_valid)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    logic [DW-1:0] hist[$];
    bit            m_trig;
    bit            m_done;
    int            m_left;

    function automatic logic [DW-1:0] pat(input logic [7:0] c);
        logic [7:0] hi;
        hi = (c * 8'd3) ^ 8'h5A;
        return {hi, c};
    endfunction

    function automatic bit model_hit(input logic [DW-1:0] s);
        bit any_m, all_m;
        any_m = 1'b0;
        all_m = 1'b1;
        if (port_en == '0) return 1'b0;
        for (int p = 0; p < NP; p++) begin
            if (port_en[p]) begin
                if (((s[p*PW +: PW] ^ cmp_value[p*PW +: PW]) & cmp_mask[p*PW +: PW]) == '0)
                    any_m = 1'b1;
                else
                    all_m = 1'b0;
            end
        end
        return comb_all ? all_m : any_m;
    endfunction

    // ---------------- scoreboard ----------------
    logic [DW:0] exp_q[$];
    string       tag_q[$];
    logic        rd_req = 1'b0;
    logic        rd_req_d = 1'b0;

    always @(posedge clk) rd_req_d <= rd_req;

    always @(negedge clk) begin
        if (rd_req_d) begin
            logic [DW:0] e;
            string t;
            if (exp_q.size() == 0) begin
                chk("R8 scoreboard underflow", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " valid flag"}, {31'd0, rd_valid}, {31'd0, e[DW]});
                if (e[DW]) chk({t, " data"}, {16'd0, rd_data}, {16'd0, e[DW-1:0]});
            end
        end
    end

    task automatic run_capture(input logic [DW-1:0] val, input logic [DW-1:0] msk,
                               input logic [NP-1:0] en, input logic mode, input int pos,
                               input int limit, input logic [7:0] start, input string trig_tag);
        logic [7:0]    c;
        logic [DW-1:0] s;
        @(negedge clk);
        cmp_value = val;
        cmp_mask  = msk;
        port_en   = en;
        comb_all  = mode;
        trig_pos  = AW'(pos);
        probe     = pat(start);
        arm       = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arm = 1'b0;
        chk("R2 armed after arm", {31'd0, armed}, 32'd1);
        chk("R2 triggered cleared", {31'd0, triggered}, 32'd0);
        chk("R2 done cleared", {31'd0, done}, 32'd0);
        hist.delete();
        m_trig = 1'b0;
        m_done = 1'b0;
        m_left = 0;
        c = start;
        for (int i = 0; i < limit && !m_done; i++) begin
            s = pat(c);
            probe = s;
            c = c + 8'd1;
            hist.push_back(s);
            if (hist.size() > DEPTH) void'(hist.pop_front());
            if (!m_trig) begin
                if (model_hit(s)) begin
                    m_trig = 1'b1;
                    m_left = DEPTH - 1 - pos;
                    if (m_left == 0) m_done = 1'b1;
                end
            end else begin
                m_left--;
                if (m_left == 0) m_done = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            chk(trig_tag, {31'd0, triggered}, {31'd0, m_trig});
            chk("R6 done timing", {31'd0, done}, {31'd0, m_done});
            chk("R3 armed while capturing", {31'd0, armed}, {31'd0, !m_done});
        end
    endtask

    task automatic hold_frozen(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            probe = pat(8'(i * 7 + 1));
            @(posedge clk);
            @(negedge clk);
            chk("R7 done held", {31'd0, done}, 32'd1);
        end
    endtask

    task automatic read_window(input int pos);
        int off;
        off = DEPTH - hist.size();
        for (int a = 0; a < DEPTH; a++) begin
            logic v;
            logic [DW-1:0] d;
            v = (a >= off);
            d = v ? hist[a - off] : '0;
            exp_q.push_back({v, d});
            if (a == pos) tag_q.push_back("R6 trigger slot");
            else if (!v) tag_q.push_back("R9 unwritten slot");
            else tag_q.push_back("R8 time order");
            rd_addr = AW'(a);
            rd_req  = 1'b1;
            @(negedge clk);
        end
        rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 scoreboard drained", exp_q.size(), 32'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 armed after reset", {31'd0, armed}, 32'd0);
        chk("R1 triggered after reset", {31'd0, triggered}, 32'd0);
        chk("R1 done after reset", {31'd0, done}, 32'd0);

        // R4 any-port match on port 0, trigger well inside window
        run_capture(16'h0030, 16'h00FF, 2'b01, 1'b0, 20, 300, 8'h00, "R4 trigger timing");
        chk("R4 capture ended", {31'd0, done}, 32'd1);
        hold_frozen(10);
        read_window(20);

        // R5 all-ports match, unique sample, trigger at last slot
        run_capture(16'hCF07, 16'hFF0F, 2'b11, 1'b1, DEPTH - 1, 300, 8'h40, "R5 all-ports trigger");
        chk("R6 last-slot capture ended", {31'd0, done}, 32'd1);
        read_window(DEPTH - 1);

        // R9 early trigger on 5th sample with large position
        run_capture(16'h6600, 16'hFF00, 2'b10, 1'b0, 40, 300, 8'h10, "R9 early trigger");
        chk("R9 capture ended", {31'd0, done}, 32'd1);
        read_window(40);

        // R5 disabled port ignored: port 1 would match but is disabled
        run_capture(16'h53F0, 16'hFFFF, 2'b01, 1'b1, 10, 100, 8'h00, "R5 disabled port ignored");
        chk("R5 no trigger with disabled port", {31'd0, triggered}, 32'd0);

        // R5 no port enabled, everything would match
        run_capture(16'h0000, 16'h0000, 2'b00, 1'b0, 10, 80, 8'h00, "R5 no enabled port");
        chk("R5 no trigger with no enable", {31'd0, triggered}, 32'd0);

        // R6 position 0, trigger on first sample after arming
        run_capture(16'h0000, 16'h0000, 2'b11, 1'b0, 0, 300, 8'hA0, "R6 first-sample trigger");
        chk("R6 pos0 capture ended", {31'd0, done}, 32'd1);
        read_window(0);

        finish_run();
    end

endmodule